// File: doc/BRIEF.md
# EDID I2C Register Controller Model

This block models a display I2C controller seen through four 32-bit registers: a pin-select register, a command register, a status register and a data register. The only device it can talk to is an EDID source at target address 7'h50, whose 128 bytes sit in a local store that is loaded through a byte-wide write port. No bus pins toggle. The block answers register reads as a real controller would, tracking the bus phase (idle, data or wait) and a small set of status flags.

The host chooses a display port by writing a pin code, issues a read command that carries the target address, an optional start index, a byte count and a bus-cycle code, and then polls status. Each read of the data register hands back up to four EDID bytes packed little-end first. When the last bytes of the transfer have been handed out, the phase settles to idle or wait depending on whether the cycle code asked for a stop. Two straps per port say whether a monitor is attached and whether that port is DisplayPort. Only a present, non-DisplayPort monitor makes EDID available.

Top module: `ddc_edid_ctrl`

## Requirements
- R1: Register offsets are 0 pin select, 1 command, 2 status, 3 data. After reset, pin select and command read 0, and status reads 32'h3. Status layout: bit 0 hardware-ready, bit 1 timeout/error, bit 2 active, bit 3 in-use, bits 9:8 phase (0 idle, 1 data, 2 wait), other bits 0.
- R2: Writing pin select stores bits 2:0 and clears the target selection. Codes 1 to 4 select ports 0 to 3. For a valid code the phase goes idle, active clears and hardware-ready sets. Error clears and EDID becomes available only when that port's monitor strap is 1 and its DisplayPort strap is 0; otherwise error sets.
- R3: Command fields: bit 0 read, bits 7:1 target address, bits 15:8 index, bits 24:16 total count, bits 27:25 cycle code, bit 30 software-ready, bit 31 clear-interrupt. Only address 7'h50 selects the EDID target. Any other address selects nothing, and later data reads return zero bytes.
- R4: When cycle-code bit 1 (command bit 26) is set, the EDID read pointer is loaded from the index field.
- R5: A data read while the stored command has the read bit and remaining = count - pointer is positive returns min(4, remaining) new bytes. Byte i sits in bits 8i+7:8i, the upper lanes keep their previous value, and the pointer advances by the number of bytes served.
- R6: If 4 or fewer bytes remained before a data read, the phase becomes idle for cycle codes 5 and 7 and wait for the other codes. The selection is reset, so further data reads return the last value unchanged.
- R7: Cycle code 4 (stop) takes effect only when the stored cycle code is nonzero. It then resets the selection, sets the phase to idle and clears active. Otherwise it changes neither.
- R8: Cycle codes 1, 3, 5 and 7 set the phase to data and set active.
- R9: A status read returns the current value, then sets in-use. Writing status with bit 3 set clears in-use. No other status bit is writable.
- R10: The command register always stores bit 30 as 0.
- R11: While the stored clear-interrupt bit is 1, command writes with bit 31 set have no effect. A write with bit 31 clear clears it and resets the controller: status becomes hardware-ready, plus error if EDID is unavailable, with phase idle.
- R12: An EDID byte beyond offset 127, or any byte read without a selected target and available EDID, is returned as 0 and does not advance the pointer.
- R13: Writes to the data register are ignored. A data read while the stored command lacks the read bit returns the last data value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects at the clock edge) |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while reg_rd is high |
| mon_present | input | 4 | Monitor attached, one strap per port |
| port_is_dp | input | 4 | Port is DisplayPort, one strap per port |
| edid_wr | input | 1 | EDID store write strobe |
| edid_waddr | input | 7 | EDID store byte address |
| edid_wdata | input | 8 | EDID store byte |

## Verification
The bench targets the partial last read, where only the low lanes are replaced. A design that cleared the upper lanes would return zeros where stale bytes belong. A read that crosses offset 127 must serve zeros without moving the pointer, and a design that wrapped the store would return byte 0 there. The stop code is issued both after a data-phase code and after cycle code 0, so a design that ignores the stored code would drop to idle when it should not. The clear-interrupt handshake is driven with an ignored write in between: a design that stored that write or skipped the reset would show the wrong command readback or a stale phase.

// File: rtl/ddc_pkg.sv
// Package: shared constants and types for the EDID I2C register model.
// Assumes a 32-bit register word and a 2-bit register offset.
package ddc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_DATA = 2'd1,
        PH_WAIT = 2'd2
    } phase_e;

    localparam logic [1:0] OFS_PIN  = 2'd0;
    localparam logic [1:0] OFS_CMD  = 2'd1;
    localparam logic [1:0] OFS_STAT = 2'd2;
    localparam logic [1:0] OFS_DATA = 2'd3;

    localparam int CMD_READ_BIT  = 0;
    localparam int CMD_ADDR_LO   = 1;
    localparam int CMD_IDX_LO    = 8;
    localparam int CMD_CNT_LO    = 16;
    localparam int CMD_CODE_LO   = 25;
    localparam int CMD_IDXEN_BIT = 26;
    localparam int CMD_SWRDY_BIT = 30;
    localparam int CMD_CLR_BIT   = 31;

    localparam int ST_HWRDY_BIT = 0;
    localparam int ST_ERR_BIT   = 1;
    localparam int ST_ACT_BIT   = 2;
    localparam int ST_INUSE_BIT = 3;
    localparam int ST_PH_LO     = 8;

    localparam logic [2:0] CYC_NONE = 3'd0;
    localparam logic [2:0] CYC_STOP = 3'd4;

    localparam logic [6:0] EDID_TARGET = 7'h50;

endpackage

// File: rtl/ddc_pin_decode.sv
// Pin decode: maps a pin-select code onto a port index.
// Assumes codes 1..NPORTS are valid, code 0 deselects, the rest are unused.
module ddc_pin_decode #(
    parameter int NPORTS = 4,
    parameter int PIN_W  = 3,
    localparam int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic [PIN_W-1:0]  pin_code,
    output logic              pin_ok,
    output logic [PORT_W-1:0] port_idx
);

    logic [PIN_W-1:0] code_m1;

    // Valid range check and zero-based port number
    always_comb begin
        code_m1  = pin_code - PIN_W'(1);
        pin_ok   = (pin_code != '0) && (int'(pin_code) <= NPORTS);
        port_idx = PORT_W'(code_m1);
    end

endmodule

// File: rtl/ddc_edid_store.sv
// EDID byte store: one write port, LANES read ports at base+0..base+LANES-1.
// Assumes out-of-range lanes are flagged and read as 0; no reset on contents.
module ddc_edid_store #(
    parameter int EDID_BYTES = 128,
    parameter int PTR_W      = 8,
    parameter int LANES      = 4,
    localparam int AW        = $clog2(EDID_BYTES)
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [7:0]           wr_data,
    input  logic [PTR_W-1:0]     base,
    output logic [LANES*8-1:0]   lane_bytes,
    output logic [LANES-1:0]     lane_inrange
);

    logic [7:0] mem [EDID_BYTES];

    // Load path for EDID contents
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [PTR_W:0] pos;
        // Lane address and bounds test
        always_comb begin
            pos = {1'b0, base} + (PTR_W+1)'(g);
            lane_inrange[g] = (int'(pos) < EDID_BYTES);
            lane_bytes[g*8 +: 8] = lane_inrange[g] ? mem[pos[AW-1:0]] : 8'h00;
        end
    end

endmodule

// File: rtl/ddc_byte_fetch.sv
// Byte fetch: gates store lanes by request count and target availability,
// and counts how many bytes really advance the pointer.
// Assumes in-range lanes form a prefix (contiguous addresses).
module ddc_byte_fetch #(
    parameter int LANES = 4,
    localparam int NW   = $clog2(LANES + 1)
) (
    input  logic [NW-1:0]      n_req,
    input  logic               src_ok,
    input  logic [LANES*8-1:0] lane_bytes,
    input  logic [LANES-1:0]   lane_inrange,
    output logic [LANES*8-1:0] out_bytes,
    output logic [NW-1:0]      adv
);

    // Per-lane gating and served-byte count
    always_comb begin
        adv = '0;
        for (int i = 0; i < LANES; i++) begin
            if (src_ok && lane_inrange[i] && (i < int'(n_req))) begin
                out_bytes[i*8 +: 8] = lane_bytes[i*8 +: 8];
                adv = adv + NW'(1);
            end else begin
                out_bytes[i*8 +: 8] = 8'h00;
            end
        end
    end

    // R5
    always_comb begin
        adv_le_req_chk: assert (adv <= n_req);
    end

endmodule

// File: rtl/ddc_edid_ctrl.sv
// EDID I2C register controller model (top).
// Four registers: pin select, command, status, data. Serves EDID bytes from a
// local store, tracks bus phase and status flags. Assumes reg_wr and reg_rd
// are never high together; read data is combinational from current state and
// read side effects take place at the clock edge ending the access.
module ddc_edid_ctrl #(
    parameter int NPORTS     = 4,
    parameter int EDID_BYTES = 128,
    parameter int LANES      = 4,
    localparam int PIN_W     = 3,
    localparam int PTR_W     = 8,
    localparam int CNT_W     = 9,
    localparam int LW        = CNT_W + 1,
    localparam int AW        = $clog2(EDID_BYTES),
    localparam int NW        = $clog2(LANES + 1),
    localparam int PORT_W    = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NPORTS-1:0] mon_present,
    input  logic [NPORTS-1:0] port_is_dp,
    input  logic              edid_wr,
    input  logic [AW-1:0]     edid_waddr,
    input  logic [7:0]        edid_wdata
);
    import ddc_pkg::*;

    // Architectural state
    logic [PIN_W-1:0] pin_q;
    logic [31:0]      cmd_q;
    logic [31:0]      data_q;
    logic             hwrdy_q, err_q, active_q, inuse_q;
    phase_e           phase_q;
    logic             sel_valid_q, target_q, avail_q;
    logic [PTR_W-1:0] rd_ptr_q;
    logic [CNT_W-1:0] total_q;
    logic [2:0]       cycle_q;

    // Decoded accesses
    logic wr_pin, wr_cmd, wr_stat, rd_stat, rd_data;
    logic [2:0] w_code;
    logic       stop_eff, code_is_data, cmd_locked;

    always_comb begin
        wr_pin  = reg_wr && (reg_addr == OFS_PIN);
        wr_cmd  = reg_wr && (reg_addr == OFS_CMD);
        wr_stat = reg_wr && (reg_addr == OFS_STAT);
        rd_stat = reg_rd && !reg_wr && (reg_addr == OFS_STAT);
        rd_data = reg_rd && !reg_wr && (reg_addr == OFS_DATA);
        w_code  = reg_wdata[CMD_CODE_LO +: 3];
        cmd_locked   = cmd_q[CMD_CLR_BIT];
        stop_eff     = (w_code == CYC_STOP) && (cmd_q[CMD_CODE_LO +: 3] != CYC_NONE);
        code_is_data = w_code[0];
    end

    // Pin decode and strap lookup
    logic              pin_ok;
    logic [PORT_W-1:0] port_idx;
    logic              mon_sel, dp_sel;

    ddc_pin_decode #(.NPORTS(NPORTS), .PIN_W(PIN_W)) i_pin_decode (
        .pin_code (reg_wdata[PIN_W-1:0]),
        .pin_ok   (pin_ok),
        .port_idx (port_idx)
    );

    always_comb begin
        mon_sel = mon_present[port_idx];
        dp_sel  = port_is_dp[port_idx];
    end

    // Remaining byte count and request size
    logic [LW-1:0] left;
    logic          left_pos, last_xfer, rd_xfer;
    logic [NW-1:0] n_req;

    always_comb begin
        left      = LW'(total_q) - LW'(rd_ptr_q);
        left_pos  = !left[LW-1] && (left != '0);
        last_xfer = left <= LW'(LANES);
        n_req     = last_xfer ? NW'(left) : NW'(LANES);
        rd_xfer   = rd_data && cmd_q[CMD_READ_BIT] && left_pos;
    end

    // Store and fetch
    logic [LANES*8-1:0] lane_bytes, fetch_bytes;
    logic [LANES-1:0]   lane_inrange;
    logic [NW-1:0]      adv;

    ddc_edid_store #(.EDID_BYTES(EDID_BYTES), .PTR_W(PTR_W), .LANES(LANES)) i_store (
        .clk          (clk),
        .wr_en        (edid_wr),
        .wr_addr      (edid_waddr),
        .wr_data      (edid_wdata),
        .base         (rd_ptr_q),
        .lane_bytes   (lane_bytes),
        .lane_inrange (lane_inrange)
    );

    ddc_byte_fetch #(.LANES(LANES)) i_fetch (
        .n_req        (n_req),
        .src_ok       (sel_valid_q && target_q && avail_q),
        .lane_bytes   (lane_bytes),
        .lane_inrange (lane_inrange),
        .out_bytes    (fetch_bytes),
        .adv          (adv)
    );

    // Merge fetched lanes over the previous data word
    logic [31:0] data_next;
    always_comb begin
        data_next = data_q;
        for (int i = 0; i < LANES; i++) begin
            if (i < int'(n_req)) data_next[i*8 +: 8] = fetch_bytes[i*8 +: 8];
        end
    end

    // Status word assembly
    logic [31:0] stat_word;
    always_comb begin
        stat_word = '0;
        stat_word[ST_HWRDY_BIT]     = hwrdy_q;
        stat_word[ST_ERR_BIT]       = err_q;
        stat_word[ST_ACT_BIT]       = active_q;
        stat_word[ST_INUSE_BIT]     = inuse_q;
        stat_word[ST_PH_LO +: 2]    = phase_q;
    end

    // Read mux
    always_comb begin
        unique case (reg_addr)
            OFS_PIN:  reg_rdata = {{(32-PIN_W){1'b0}}, pin_q};
            OFS_CMD:  reg_rdata = cmd_q;
            OFS_STAT: reg_rdata = stat_word;
            default:  reg_rdata = rd_xfer ? data_next : data_q;
        endcase
    end

    // Selection reset request
    logic init_sel;
    always_comb begin
        init_sel = wr_pin
                || (wr_cmd && !cmd_locked && stop_eff)
                || (rd_xfer && last_xfer);
    end

    // Register and bus-state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q       <= '0;
            cmd_q       <= '0;
            data_q      <= '0;
            hwrdy_q     <= 1'b1;
            err_q       <= 1'b1;
            active_q    <= 1'b0;
            inuse_q     <= 1'b0;
            phase_q     <= PH_IDLE;
            sel_valid_q <= 1'b0;
            target_q    <= 1'b0;
            avail_q     <= 1'b0;
            rd_ptr_q    <= '0;
            total_q     <= '0;
            cycle_q     <= CYC_NONE;
        end else begin
            if (init_sel) begin
                sel_valid_q <= 1'b0;
                target_q    <= 1'b0;
                avail_q     <= 1'b0;
                rd_ptr_q    <= '0;
                total_q     <= '0;
                cycle_q     <= CYC_NONE;
                phase_q     <= PH_IDLE;
            end

            if (wr_pin) begin
                pin_q <= reg_wdata[PIN_W-1:0];
                if (pin_ok) begin
                    sel_valid_q <= 1'b1;
                    phase_q     <= PH_IDLE;
                    active_q    <= 1'b0;
                    hwrdy_q     <= 1'b1;
                    if (mon_sel && !dp_sel) begin
                        avail_q <= 1'b1;
                        err_q   <= 1'b0;
                    end else begin
                        err_q   <= 1'b1;
                    end
                end
            end

            if (wr_cmd) begin
                if (cmd_locked) begin
                    if (!reg_wdata[CMD_CLR_BIT]) begin
                        cmd_q[CMD_CLR_BIT] <= 1'b0;
                        hwrdy_q  <= 1'b1;
                        err_q    <= !avail_q;
                        active_q <= 1'b0;
                        inuse_q  <= 1'b0;
                        phase_q  <= PH_IDLE;
                    end
                end else begin
                    if (reg_wdata[CMD_CLR_BIT]) hwrdy_q <= 1'b1;
                    cmd_q <= reg_wdata & ~(32'd1 << CMD_SWRDY_BIT);
                    if (!stop_eff) begin
                        total_q <= reg_wdata[CMD_CNT_LO +: CNT_W];
                        cycle_q <= w_code;
                        if (reg_wdata[CMD_ADDR_LO +: 7] == EDID_TARGET) target_q <= 1'b1;
                        if (reg_wdata[CMD_IDXEN_BIT]) rd_ptr_q <= reg_wdata[CMD_IDX_LO +: PTR_W];
                    end
                    if (stop_eff) begin
                        phase_q  <= PH_IDLE;
                        active_q <= 1'b0;
                    end else if (code_is_data) begin
                        phase_q  <= PH_DATA;
                        active_q <= 1'b1;
                    end
                end
            end

            if (wr_stat && reg_wdata[ST_INUSE_BIT]) inuse_q <= 1'b0;
            if (rd_stat) inuse_q <= 1'b1;

            if (rd_xfer) begin
                data_q <= data_next;
                if (last_xfer) begin
                    phase_q <= (cycle_q[2] && cycle_q[0]) ? PH_IDLE : PH_WAIT;
                end else begin
                    rd_ptr_q <= rd_ptr_q + PTR_W'(adv);
                end
            end
        end
    end

    // R9
    inuse_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |=> inuse_q);

    // R9
    inuse_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && reg_wdata[ST_INUSE_BIT] && !reg_rd) |=> !inuse_q);

    // R7
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && !cmd_q[CMD_CLR_BIT] && (reg_wdata[27:25] == 3'd4)
         && (cmd_q[27:25] != 3'd0)) |=> (phase_q == PH_IDLE) && !active_q);

    // R8
    data_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && !cmd_q[CMD_CLR_BIT] && reg_wdata[25]) |=> (phase_q == PH_DATA) && active_q);

    // R10
    swrdy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd |=> !reg_rdata[CMD_SWRDY_BIT] || (reg_addr != OFS_CMD));

    // R13
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == OFS_DATA)) |=> $stable(data_q));

endmodule

// File: tb/test_ddc_edid_ctrl.sv
module test_ddc_edid_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  mon_present = 4'b0111;
    logic [3:0]  port_is_dp  = 4'b0010;
    logic        edid_wr = 1'b0;
    logic [6:0]  edid_waddr = '0;
    logic [7:0]  edid_wdata = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    ddc_edid_ctrl i_ddc_edid_ctrl (
        .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
        .mon_present, .port_is_dp, .edid_wr, .edid_waddr, .edid_wdata
    );

    localparam logic [1:0] A_PIN = 2'd0, A_CMD = 2'd1, A_STAT = 2'd2, A_DATA = 2'd3;

    function automatic logic [7:0] eb(input int k);
        return 8'((k * 37 + 11) & 255);
    endfunction

    function automatic logic [31:0] mk(input int code, input int cnt, input int idx,
                                       input int addr, input int rd);
        return (32'(code) << 25) | (32'(cnt) << 16) | (32'(idx) << 8)
             | (32'(addr) << 1) | 32'(rd);
    endfunction

    function automatic logic [31:0] pack(input int k);
        return {eb(k+3), eb(k+2), eb(k+1), eb(k)};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic chk_stat(input string req, input logic [31:0] exp);
        logic [31:0] v;
        rd(A_STAT, v);
        check(req, v & ~32'h8, exp);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_PIN, v);  check("R1 pin reset", v, 32'h0);
        rd(A_CMD, v);  check("R1 cmd reset", v, 32'h0);
        rd(A_STAT, v); check("R1 status reset", v, 32'h3);
    endtask

    task automatic t_pin;
        logic [31:0] v;
        wr(A_PIN, 1); chk_stat("R2 port B available", 32'h1);
        wr(A_PIN, 2); chk_stat("R2 DP port error", 32'h3);
        wr(A_PIN, 4); chk_stat("R2 absent monitor error", 32'h3);
        rd(A_PIN, v); check("R1 pin readback", v, 32'h4);
    endtask

    task automatic t_seq8;
        logic [31:0] v, first;
        wr(A_PIN, 1);
        wr(A_CMD, mk(5, 8, 0, 'h50, 1));
        chk_stat("R8 data phase", 32'h105);
        rd(A_DATA, v); check("R5 bytes 0-3", v, pack(0));
        rd(A_DATA, v); check("R5 bytes 4-7", v, pack(4));
        first = v;
        chk_stat("R6 stop type idle", 32'h005);
        rd(A_DATA, v); check("R6 no further bytes", v, first);
    endtask

    task automatic t_index;
        logic [31:0] v;
        wr(A_PIN, 1);
        wr(A_CMD, mk(3, 16, 10, 'h50, 1));
        rd(A_DATA, v); check("R4 index start", v, pack(10));
        rd(A_DATA, v); check("R5 partial keeps upper lanes", v, {eb(13), eb(12), eb(15), eb(14)});
        chk_stat("R6 no-stop type wait", 32'h205);
    endtask

    task automatic t_past;
        logic [31:0] v;
        wr(A_PIN, 1);
        wr(A_CMD, mk(7, 131, 126, 'h50, 1));
        rd(A_DATA, v); check("R12 end of store", v, {16'h0, eb(127), eb(126)});
        rd(A_DATA, v); check("R12 past store zero", v, 32'h0);
    endtask

    task automatic t_notarget;
        logic [31:0] v;
        wr(A_PIN, 1);
        wr(A_CMD, mk(7, 4, 0, 'h37, 1));
        rd(A_DATA, v); check("R3 other address ignored", v, 32'h0);
        wr(A_PIN, 4);
        wr(A_CMD, mk(7, 4, 0, 'h50, 1));
        rd(A_DATA, v); check("R12 no EDID zero", v, 32'h0);
    endtask

    task automatic t_stop;
        wr(A_PIN, 1);
        wr(A_CMD, mk(1, 8, 0, 'h50, 1));
        chk_stat("R8 wait-type data phase", 32'h105);
        wr(A_CMD, mk(4, 0, 0, 0, 0));
        chk_stat("R7 stop takes effect", 32'h001);
        wr(A_CMD, mk(1, 8, 0, 'h50, 1));
        wr(A_CMD, mk(0, 0, 0, 0, 0));
        wr(A_CMD, mk(4, 0, 0, 0, 0));
        chk_stat("R7 stop after code 0 ignored", 32'h105);
    endtask

    task automatic t_swrdy;
        logic [31:0] v;
        wr(A_CMD, mk(0, 5, 0, 'h50, 1) | 32'h4000_0000);
        rd(A_CMD, v); check("R10 sw-ready stored 0", v, mk(0, 5, 0, 'h50, 1));
    endtask

    task automatic t_clr;
        logic [31:0] v;
        wr(A_PIN, 1);
        wr(A_CMD, mk(1, 8, 0, 'h50, 1));
        wr(A_CMD, 32'h8000_0000);
        rd(A_CMD, v); check("R11 clear bit stored", v, 32'h8000_0000);
        wr(A_CMD, mk(5, 8, 0, 'h50, 1) | 32'h8000_0000);
        rd(A_CMD, v); check("R11 locked write ignored", v, 32'h8000_0000);
        chk_stat("R11 phase untouched", 32'h105);
        wr(A_CMD, 32'h0);
        rd(A_STAT, v); check("R11 reset with EDID", v, 32'h001);
        rd(A_CMD, v); check("R11 clear bit dropped", v, 32'h0);
        wr(A_PIN, 4);
        wr(A_CMD, 32'h8000_0000);
        wr(A_CMD, 32'h0);
        rd(A_STAT, v); check("R11 reset without EDID", v, 32'h003);
    endtask

    task automatic t_inuse;
        logic [31:0] v;
        rd(A_STAT, v);
        rd(A_STAT, v); check("R9 in-use set by read", v & 32'h8, 32'h8);
        wr(A_STAT, 32'h0000_0304);
        rd(A_STAT, v); check("R9 other bits read-only", v, 32'h00B);
        wr(A_STAT, 32'h8);
        rd(A_STAT, v); check("R9 in-use cleared", v, 32'h003);
    endtask

    task automatic t_dataw;
        logic [31:0] v;
        wr(A_PIN, 1);
        wr(A_CMD, mk(5, 4, 0, 'h50, 1));
        rd(A_DATA, v); check("R5 full word", v, pack(0));
        wr(A_DATA, 32'hDEAD_BEEF);
        wr(A_CMD, mk(0, 8, 0, 'h50, 0));
        rd(A_DATA, v); check("R13 write ignored, non-read cmd", v, pack(0));
    endtask

    initial begin
        for (int k = 0; k < 128; k++) begin
            @(negedge clk);
            edid_wr = 1'b1; edid_waddr = 7'(k); edid_wdata = eb(k);
        end
        @(negedge clk);
        edid_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_pin;
        t_seq8;
        t_index;
        t_past;
        t_notarget;
        t_stop;
        t_swrdy;
        t_clr;
        t_inuse;
        t_dataw;
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule